// File: doc/BRIEF.md
# EX-Stage Operand Forwarding and Load-Use Interlock

This block sits beside the execute stage of a five-stage integer pipeline that keeps one extra register after write-back. Each cycle it examines the instruction held in ID/EX and decides where each of its two ALU operands should come from. An operand comes from the value read in decode, or from a result still travelling down the pipe in EX/MEM, MEM/WB or the post-write-back register WB/END. Because WB/END holds the value written to the register file one cycle earlier, the register file never has to bypass a write to a read within the same cycle.

The block is purely combinational. It also looks at the instruction waiting in IF/ID to catch the one dependence that forwarding cannot resolve: a load whose result is needed by the very next instruction. In that case it asks fetch and IF/ID to hold their values and supplies a noop word as the next ID/EX instruction.

Instruction fields: the opcode is in bits 24-22, regA in bits 21-19, regB in bits 18-16 and the R-type destination in bits 2-0. The opcodes are add 000, nand 001, lw 010, sw 011, beq 100, mult 101, halt 110 and noop 111.

Top module: `ex_operand_fwd`

## Requirements
- R1: When no downstream source matches, operandA equals idExReadA and operandB equals idExReadB.
- R2: When the EX/MEM instruction writes the register named by the ID/EX regA (or regB) field, that operand takes exMemAluResult.
- R3: A matching MEM/WB source supplies memWbWriteData, and a matching WB/END source supplies wbEndWriteData.
- R4: When several sources match the same operand, EX/MEM wins over MEM/WB, and MEM/WB wins over WB/END.
- R5: add, nand and mult name their destination in bits 2-0. lw names its destination in bits 18-16. A register in any other field of a source is not matched.
- R6: sw, beq, halt and noop in a downstream stage are never forwarding sources.
- R7: A destination of register 0 is never forwarded. An operand field of 0 always uses the decode-read value.
- R8: When ID/EX holds lw with a nonzero destination and the IF/ID instruction reads that register, holdFetch and insertBubble are both 1. An instruction reads regA if it is add, nand, mult, lw, sw or beq. It reads regB if it is add, nand, mult, sw or beq.
- R9: While insertBubble is 1, idExInstrNext is the noop word 0x01C00000. Otherwise it equals ifIdInstr.
- R10: There is no stall when the ID/EX instruction is not lw, when the load destination is 0, or when the IF/ID instruction does not read the loaded register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idExInstr | input | 32 | Instruction in ID/EX |
| idExReadA | input | 32 | regA value read in decode |
| idExReadB | input | 32 | regB value read in decode |
| ifIdInstr | input | 32 | Instruction in IF/ID |
| exMemInstr | input | 32 | Instruction in EX/MEM |
| exMemAluResult | input | 32 | ALU result in EX/MEM |
| memWbInstr | input | 32 | Instruction in MEM/WB |
| memWbWriteData | input | 32 | Write-back value in MEM/WB |
| wbEndInstr | input | 32 | Instruction in WB/END |
| wbEndWriteData | input | 32 | Value written one cycle earlier |
| operandA | output | 32 | Selected first ALU operand |
| operandB | output | 32 | Selected second ALU operand |
| holdFetch | output | 1 | Freeze PC and IF/ID |
| insertBubble | output | 1 | Load a noop into ID/EX |
| idExInstrNext | output | 32 | Instruction to load into ID/EX |

## Verification
The selection logic is tried with a single source writing regA and then regB, with each of the three stages as that source, and with two or three stages writing the same register. These show whether the right stage and the right data field are chosen, and in which priority. Sources whose bits 2-0 and bits 18-16 name different registers show whether the destination field is decoded per opcode. Non-writing opcodes and register 0 are placed where a naive match would fire. The interlock is tried with load consumers that read the loaded register through regA, through regB, and not at all, with a load into register 0, and with a non-load producer.

// File: rtl/ex_fwd_pkg.sv
package ex_fwd_pkg;

  localparam int INSTR_W  = 32;
  localparam int OPC_LSB  = 22;
  localparam int OPC_W    = 3;
  localparam int RIDX_W   = 3;
  localparam int REGA_LSB = 19;
  localparam int REGB_LSB = 16;
  localparam int DEST_LSB = 0;
  localparam int NUM_SRC  = 3;   // 0: EX/MEM, 1: MEM/WB, 2: WB/END (priority order)

  typedef enum logic [OPC_W-1:0] {
    OP_ADD  = 3'd0,
    OP_NAND = 3'd1,
    OP_LW   = 3'd2,
    OP_SW   = 3'd3,
    OP_BEQ  = 3'd4,
    OP_MULT = 3'd5,
    OP_HALT = 3'd6,
    OP_NOOP = 3'd7
  } opcode_e;

  localparam logic [INSTR_W-1:0] NOOP_WORD = 32'h01C0_0000;

  typedef logic [RIDX_W-1:0] regIdx_t;

  typedef struct packed {
    logic [NUM_SRC-1:0] pickA;
    logic [NUM_SRC-1:0] pickB;
    logic               bubble;
  } fwdStrobe_t;

  function automatic opcode_e opcodeOf(input logic [INSTR_W-1:0] instr);
    return opcode_e'(instr[OPC_LSB +: OPC_W]);
  endfunction

  function automatic regIdx_t regAOf(input logic [INSTR_W-1:0] instr);
    return instr[REGA_LSB +: RIDX_W];
  endfunction

  function automatic regIdx_t regBOf(input logic [INSTR_W-1:0] instr);
    return instr[REGB_LSB +: RIDX_W];
  endfunction

  function automatic logic writesReg(input opcode_e op);
    return (op == OP_ADD) || (op == OP_NAND) || (op == OP_MULT) || (op == OP_LW);
  endfunction

  function automatic regIdx_t destOf(input logic [INSTR_W-1:0] instr);
    if (opcodeOf(instr) == OP_LW) return regBOf(instr);
    return instr[DEST_LSB +: RIDX_W];
  endfunction

  function automatic logic readsA(input opcode_e op);
    return (op == OP_ADD) || (op == OP_NAND) || (op == OP_MULT) ||
           (op == OP_LW)  || (op == OP_SW)   || (op == OP_BEQ);
  endfunction

  function automatic logic readsB(input opcode_e op);
    return (op == OP_ADD) || (op == OP_NAND) || (op == OP_MULT) ||
           (op == OP_SW)  || (op == OP_BEQ);
  endfunction

endpackage

// File: rtl/ex_fwd_ctrl.sv
module ex_fwd_ctrl
  import ex_fwd_pkg::*;
(
  input  logic [INSTR_W-1:0]              idExInstr,
  input  logic [INSTR_W-1:0]              ifIdInstr,
  input  logic [NUM_SRC-1:0][INSTR_W-1:0] srcInstr,
  output fwdStrobe_t                      strobe
);

  logic [NUM_SRC-1:0] hitA;
  logic [NUM_SRC-1:0] hitB;
  regIdx_t            useA;
  regIdx_t            useB;

  assign useA = regAOf(idExInstr);
  assign useB = regBOf(idExInstr);

  // Per-source match: the source must write a register, its destination must
  // be nonzero, and it must equal the operand field in ID/EX.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic    srcWrites;
    regIdx_t srcDest;
    assign srcWrites = writesReg(opcodeOf(srcInstr[s]));
    assign srcDest   = destOf(srcInstr[s]);
    assign hitA[s]   = srcWrites && (srcDest != '0) && (srcDest == useA);
    assign hitB[s]   = srcWrites && (srcDest != '0) && (srcDest == useB);
  end

  // Priority pick: the lowest index (youngest result) wins.
  logic [NUM_SRC-1:0] pickA;
  logic [NUM_SRC-1:0] pickB;
  always_comb begin
    logic doneA;
    logic doneB;
    pickA = '0;
    pickB = '0;
    doneA = 1'b0;
    doneB = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (hitA[s] && !doneA) begin
        pickA[s] = 1'b1;
        doneA    = 1'b1;
      end
      if (hitB[s] && !doneB) begin
        pickB[s] = 1'b1;
        doneB    = 1'b1;
      end
    end
  end

  // Load-use detection between ID/EX (load) and IF/ID (consumer).
  logic    loadInEx;
  regIdx_t loadDest;
  opcode_e nextOp;
  logic    nextUsesLoad;

  assign loadInEx     = (opcodeOf(idExInstr) == OP_LW);
  assign loadDest     = regBOf(idExInstr);
  assign nextOp       = opcodeOf(ifIdInstr);
  assign nextUsesLoad = (readsA(nextOp) && (regAOf(ifIdInstr) == loadDest)) ||
                        (readsB(nextOp) && (regBOf(ifIdInstr) == loadDest));

  assign strobe.pickA  = pickA;
  assign strobe.pickB  = pickB;
  assign strobe.bubble = loadInEx && (loadDest != '0) && nextUsesLoad;

  // R4
  always_comb begin
    if (!$isunknown({idExInstr, srcInstr})) begin
      pick_onehot_chk: assert ($onehot0(pickA) && $onehot0(pickB))
        else $error("more than one forwarding source picked");
    end
  end

endmodule

// File: rtl/ex_fwd_datapath.sv
module ex_fwd_datapath
  import ex_fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwdStrobe_t                     strobe,
  input  logic [DATA_W-1:0]              readA,
  input  logic [DATA_W-1:0]              readB,
  input  logic [NUM_SRC-1:0][DATA_W-1:0] srcData,
  input  logic [INSTR_W-1:0]             ifIdInstr,
  output logic [DATA_W-1:0]              operandA,
  output logic [DATA_W-1:0]              operandB,
  output logic                           holdFetch,
  output logic                           insertBubble,
  output logic [INSTR_W-1:0]             idExInstrNext
);

  // One-hot select: AND-OR mux over the sources, decode value as fallback.
  logic [NUM_SRC-1:0][DATA_W-1:0] termA;
  logic [NUM_SRC-1:0][DATA_W-1:0] termB;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_term
    assign termA[s] = srcData[s] & {DATA_W{strobe.pickA[s]}};
    assign termB[s] = srcData[s] & {DATA_W{strobe.pickB[s]}};
  end

  always_comb begin
    operandA = readA & {DATA_W{~|strobe.pickA}};
    operandB = readB & {DATA_W{~|strobe.pickB}};
    for (int s = 0; s < NUM_SRC; s++) begin
      operandA = operandA | termA[s];
      operandB = operandB | termB[s];
    end
  end

  assign holdFetch     = strobe.bubble;
  assign insertBubble  = strobe.bubble;
  assign idExInstrNext = strobe.bubble ? NOOP_WORD : ifIdInstr;

endmodule

// File: rtl/ex_operand_fwd.sv
module ex_operand_fwd
  import ex_fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [INSTR_W-1:0] idExInstr,
  input  logic [DATA_W-1:0]  idExReadA,
  input  logic [DATA_W-1:0]  idExReadB,
  input  logic [INSTR_W-1:0] ifIdInstr,
  input  logic [INSTR_W-1:0] exMemInstr,
  input  logic [DATA_W-1:0]  exMemAluResult,
  input  logic [INSTR_W-1:0] memWbInstr,
  input  logic [DATA_W-1:0]  memWbWriteData,
  input  logic [INSTR_W-1:0] wbEndInstr,
  input  logic [DATA_W-1:0]  wbEndWriteData,
  output logic [DATA_W-1:0]  operandA,
  output logic [DATA_W-1:0]  operandB,
  output logic               holdFetch,
  output logic               insertBubble,
  output logic [INSTR_W-1:0] idExInstrNext
);

  logic [NUM_SRC-1:0][INSTR_W-1:0] srcInstr;
  logic [NUM_SRC-1:0][DATA_W-1:0]  srcData;
  fwdStrobe_t                      strobe;

  assign srcInstr = {wbEndInstr, memWbInstr, exMemInstr};
  assign srcData  = {wbEndWriteData, memWbWriteData, exMemAluResult};

  ex_fwd_ctrl u_ctrl (
    .idExInstr (idExInstr),
    .ifIdInstr (ifIdInstr),
    .srcInstr  (srcInstr),
    .strobe    (strobe)
  );

  ex_fwd_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobe        (strobe),
    .readA         (idExReadA),
    .readB         (idExReadB),
    .srcData       (srcData),
    .ifIdInstr     (ifIdInstr),
    .operandA      (operandA),
    .operandB      (operandB),
    .holdFetch     (holdFetch),
    .insertBubble  (insertBubble),
    .idExInstrNext (idExInstrNext)
  );

  logic inputsKnown;
  assign inputsKnown = !$isunknown({idExInstr, idExReadA, idExReadB, ifIdInstr,
                                    exMemInstr, exMemAluResult, memWbInstr,
                                    memWbWriteData, wbEndInstr, wbEndWriteData});

  always_comb begin
    if (inputsKnown) begin
      // R7
      zero_reg_chk: assert ((regAOf(idExInstr) != '0) || (operandA == idExReadA))
        else $error("register 0 operand was forwarded");
      // R9
      bubble_word_chk: assert (!insertBubble || (holdFetch && idExInstrNext == NOOP_WORD))
        else $error("bubble without noop word or fetch hold");
      // R8
      stall_cause_chk: assert (!holdFetch || (opcodeOf(idExInstr) == OP_LW))
        else $error("stall raised without a load in ID/EX");
      // R6
      quiet_src_chk: assert (writesReg(opcodeOf(exMemInstr)) ||
                             writesReg(opcodeOf(memWbInstr)) ||
                             writesReg(opcodeOf(wbEndInstr)) ||
                             (operandA == idExReadA && operandB == idExReadB))
        else $error("forwarded from a non-writing instruction");
    end
  end

endmodule

// File: tb/ex_operand_fwd_bench.sv
module ex_operand_fwd_bench;
  import ex_fwd_pkg::*;

  localparam int DW = 32;
  localparam logic [31:0] NOOPW = 32'h01C0_0000;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic [31:0] idExInstr, idExReadA, idExReadB, ifIdInstr;
  logic [31:0] exMemInstr, exMemAluResult, memWbInstr, memWbWriteData;
  logic [31:0] wbEndInstr, wbEndWriteData;
  logic [31:0] operandA, operandB, idExInstrNext;
  logic        holdFetch, insertBubble;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  ex_operand_fwd #(.DATA_W(DW)) u_ex_operand_fwd (
    .idExInstr(idExInstr), .idExReadA(idExReadA), .idExReadB(idExReadB),
    .ifIdInstr(ifIdInstr), .exMemInstr(exMemInstr), .exMemAluResult(exMemAluResult),
    .memWbInstr(memWbInstr), .memWbWriteData(memWbWriteData),
    .wbEndInstr(wbEndInstr), .wbEndWriteData(wbEndWriteData),
    .operandA(operandA), .operandB(operandB), .holdFetch(holdFetch),
    .insertBubble(insertBubble), .idExInstrNext(idExInstrNext)
  );

  function automatic logic [31:0] mkR(input logic [2:0] op, input logic [2:0] a,
                                      input logic [2:0] b, input logic [2:0] d);
    return {7'b0, op, a, b, 13'b0, d};
  endfunction

  function automatic logic [31:0] mkI(input logic [2:0] op, input logic [2:0] a,
                                      input logic [2:0] b, input logic [15:0] off);
    return {7'b0, op, a, b, off};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    idExInstr = NOOPW; ifIdInstr = NOOPW;
    exMemInstr = NOOPW; memWbInstr = NOOPW; wbEndInstr = NOOPW;
    idExReadA = 32'h11; idExReadB = 32'h22;
    exMemAluResult = 32'hAAAA_0001; memWbWriteData = 32'hBBBB_0002;
    wbEndWriteData = 32'hCCCC_0003;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic t_idle();
    idle(); settle();
    check("R1 operandA", operandA, 32'h11);
    check("R1 operandB", operandB, 32'h22);
    check("R10 hold idle", {31'b0, holdFetch}, 32'd0);
    check("R9 next idle", idExInstrNext, NOOPW);
  endtask

  task automatic t_exmem();
    idle();
    exMemInstr = mkR(3'd0, 3'd4, 3'd5, 3'd1);
    idExInstr  = mkR(3'd1, 3'd1, 3'd2, 3'd3);
    settle();
    check("R2 regA from EX/MEM", operandA, 32'hAAAA_0001);
    check("R1 regB untouched", operandB, 32'h22);
    idExInstr = mkR(3'd0, 3'd2, 3'd1, 3'd3);
    settle();
    check("R2 regB from EX/MEM", operandB, 32'hAAAA_0001);
    check("R2 regA untouched", operandA, 32'h11);
  endtask

  task automatic t_later();
    idle();
    memWbInstr = mkI(3'd2, 3'd0, 3'd3, 16'd9);
    wbEndInstr = mkR(3'd1, 3'd0, 3'd0, 3'd4);
    idExInstr  = mkR(3'd5, 3'd3, 3'd4, 3'd1);
    settle();
    check("R3 regA from MEM/WB", operandA, 32'hBBBB_0002);
    check("R3 regB from WB/END", operandB, 32'hCCCC_0003);
  endtask

  task automatic t_priority();
    idle();
    exMemInstr = mkR(3'd0, 3'd0, 3'd0, 3'd5);
    memWbInstr = mkR(3'd5, 3'd0, 3'd0, 3'd5);
    wbEndInstr = mkI(3'd2, 3'd0, 3'd5, 16'd1);
    idExInstr  = mkR(3'd0, 3'd5, 3'd5, 3'd1);
    settle();
    check("R4 EX/MEM first A", operandA, 32'hAAAA_0001);
    check("R4 EX/MEM first B", operandB, 32'hAAAA_0001);
    exMemInstr = NOOPW;
    settle();
    check("R4 MEM/WB over WB/END", operandA, 32'hBBBB_0002);
  endtask

  task automatic t_destField();
    idle();
    exMemInstr = mkR(3'd0, 3'd0, 3'd6, 3'd2);
    idExInstr  = mkR(3'd0, 3'd6, 3'd2, 3'd1);
    settle();
    check("R5 R-type regB field not a dest", operandA, 32'h11);
    check("R5 R-type dest bits 2-0", operandB, 32'hAAAA_0001);
    exMemInstr = mkI(3'd2, 3'd0, 3'd6, 16'd2);
    settle();
    check("R5 lw dest bits 18-16", operandA, 32'hAAAA_0001);
    check("R5 lw low bits not a dest", operandB, 32'h22);
  endtask

  task automatic t_nonWriters();
    logic [2:0] ops [4];
    ops[0] = 3'd3; ops[1] = 3'd4; ops[2] = 3'd6; ops[3] = 3'd7;
    for (int k = 0; k < 4; k++) begin
      idle();
      exMemInstr = {7'b0, ops[k], 3'd2, 3'd2, 16'd2};
      memWbInstr = {7'b0, ops[k], 3'd2, 3'd2, 16'd2};
      idExInstr  = mkR(3'd0, 3'd2, 3'd2, 3'd1);
      settle();
      check($sformatf("R6 op %0d A", ops[k]), operandA, 32'h11);
      check($sformatf("R6 op %0d B", ops[k]), operandB, 32'h22);
    end
  endtask

  task automatic t_zero();
    idle();
    exMemInstr = mkR(3'd0, 3'd1, 3'd1, 3'd0);
    wbEndInstr = mkI(3'd2, 3'd1, 3'd0, 16'd0);
    idExInstr  = mkR(3'd0, 3'd0, 3'd0, 3'd1);
    settle();
    check("R7 zero regA", operandA, 32'h11);
    check("R7 zero regB", operandB, 32'h22);
  endtask

  task automatic t_loadUse();
    idle();
    idExInstr = mkI(3'd2, 3'd0, 3'd3, 16'd4);
    ifIdInstr = mkR(3'd0, 3'd3, 3'd1, 3'd4);
    settle();
    check("R8 stall via regA", {31'b0, holdFetch}, 32'd1);
    check("R8 bubble via regA", {31'b0, insertBubble}, 32'd1);
    check("R9 noop inserted", idExInstrNext, NOOPW);
    ifIdInstr = mkI(3'd3, 3'd1, 3'd3, 16'd0);
    settle();
    check("R8 stall via sw regB", {31'b0, holdFetch}, 32'd1);
    ifIdInstr = mkI(3'd2, 3'd3, 3'd5, 16'd0);
    settle();
    check("R8 stall via lw base", {31'b0, insertBubble}, 32'd1);
  endtask

  task automatic t_noStall();
    idle();
    idExInstr = mkI(3'd2, 3'd0, 3'd3, 16'd4);
    ifIdInstr = mkI(3'd6, 3'd3, 3'd3, 16'd0);
    settle();
    check("R10 halt consumer", {31'b0, holdFetch}, 32'd0);
    check("R9 passthrough", idExInstrNext, ifIdInstr);
    ifIdInstr = mkI(3'd2, 3'd1, 3'd3, 16'd0);
    settle();
    check("R10 lw regB not read", {31'b0, insertBubble}, 32'd0);
    idExInstr = mkI(3'd2, 3'd3, 3'd0, 16'd4);
    ifIdInstr = mkR(3'd0, 3'd0, 3'd0, 3'd2);
    settle();
    check("R10 load into reg 0", {31'b0, holdFetch}, 32'd0);
    idExInstr = mkR(3'd0, 3'd1, 3'd1, 3'd3);
    ifIdInstr = mkR(3'd0, 3'd3, 3'd3, 3'd2);
    settle();
    check("R10 non-load producer", {31'b0, holdFetch}, 32'd0);
  endtask

  initial begin
    t_idle();
    t_exmem();
    t_later();
    t_priority();
    t_destField();
    t_nonWriters();
    t_zero();
    t_loadUse();
    t_noStall();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule